// File: doc/BRIEF.md
# Carrier Sense and Collision Controller

This block drives the carrier-sense and collision lines that a serial-link MAC watches. It merges a receive-activity flag with a collision detector that watches a sampled collision tone. The result is a carrier indication, which the block gates in three cases: after a transmission it enforces a quiet window, a watchdog abort forces it off, and in loopback it is taken from the local transmit enable instead of the line. In loopback, at the end of each frame, the block also emits a short simulated signal-quality-test collision pulse. A mode input inverts both outputs for controllers that expect active-low lines.

The sequencer has seven states. IDLE moves to RX_CARRIER on activity without transmit, or to TX_CARRIER on activity with transmit. RX_CARRIER moves to TX_CARRIER when transmit starts, and back to IDLE as soon as activity ends, with no quiet window. TX_CARRIER goes to INHIBIT when activity ends in normal mode, or to SQE_WAIT in loopback. SQE_WAIT becomes SQE_PULSE after the delay. SQE_PULSE becomes INHIBIT after the pulse width. INHIBIT leaves after the full window, to RX_CARRIER, TX_CARRIER, IDLE or ABORT depending on the inputs at that moment. A watchdog abort takes IDLE, RX_CARRIER and TX_CARRIER to ABORT. ABORT moves to INHIBIT once both transmit enable and the abort are low. The collision detector has three states. DET_IDLE goes to DET_ARMED on one tone edge. DET_ARMED goes to DET_ACTIVE on a second edge, or back to DET_IDLE after a gap with no edge. DET_ACTIVE returns to DET_IDLE after a gap with no edge. Loopback clears the detector.

Every timer counts cycles of a 20 MHz clock. The defaults are a 90-cycle window (4.5 µs), an 11-cycle delay before the test pulse (550 ns), a 13-cycle test pulse (650 ns) and a 4-cycle edge gap (200 ns).

Top module: `carrier_sense_ctrl`

## Requirements
- R1: From IDLE, when rx_active is high or a collision is present, crs_pin goes active in the cycle after the sequencer samples that activity, and stays active while the activity lasts.
- R2: When activity ends during a reception (tx_active low), crs_pin goes inactive one cycle later and can go active again on the very next cycle, with no quiet window.
- R3: When carrier ends during a transmission (tx_active high while carrier was up), crs_pin stays inactive for exactly INHIBIT_CYC (90) cycles whatever the inputs do. If activity is present when the window ends, crs_pin goes active on cycle 90 after the drop.
- R4: A collision is declared present on the second tone edge (any change of coll_tone counts as an edge). A single edge followed by silence never declares one. Presence ends when GAP_CYC (4) cycles pass without an edge.
- R5: Outside loopback, coll_pin is active in the cycle after the second tone edge is sampled, and inactive once presence ends.
- R6: While loopback is high, rx_active and coll_tone have no effect on either output, and carrier follows tx_active.
- R7: In loopback, after carrier drops at the end of a frame, coll_pin goes active for SQE_WID (13) cycles, starting SQE_DLY (11) cycles after the drop. crs_pin stays inactive for the whole INHIBIT_CYC window.
- R8: A high wdog_abort makes crs_pin inactive from the next cycle. Carrier stays off until both tx_active and wdog_abort are low, and the INHIBIT_CYC window then follows.
- R9: With invert_pol at 1, both outputs are active low: the pin value is the inverse of the active-high value. With invert_pol at 0, they are active high.
- R10: During and just after reset, both outputs are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_active | input | 1 | Receive data present on the line |
| tx_active | input | 1 | Local transmit enable |
| coll_tone | input | 1 | Sampled, noise-filtered collision tone |
| wdog_abort | input | 1 | Transmit watchdog has expired |
| loopback | input | 1 | Loopback mode select |
| invert_pol | input | 1 | 1 makes both outputs active low |
| crs_pin | output | 1 | Carrier sense to the MAC |
| coll_pin | output | 1 | Collision to the MAC |

## Verification
The assertions assume that coll_tone has already been sampled into the clock domain and stripped of sub-cycle glitches upstream, so that every change it shows is a real tone edge. They also assume that wdog_abort is only raised during a transmission. The stimulus changes all inputs on the falling clock edge and toggles the tone at most every other cycle, which is the slowest tone of the accepted band and sits inside the 4-cycle gap. It raises wdog_abort only while tx_active is high. Reset is applied once, at the start, so no timed window is ever interrupted by reset.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_CARRIER,
        ST_TX_CARRIER,
        ST_SQE_WAIT,
        ST_SQE_PULSE,
        ST_INHIBIT,
        ST_ABORT
    } seq_state_t;

    typedef enum logic [1:0] {
        DET_IDLE,
        DET_ARMED,
        DET_ACTIVE
    } det_state_t;

endpackage

// File: rtl/csc_coll_detect.sv
module csc_coll_detect
    import csc_pkg::*;
#(
    parameter int GAP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_i,
    input  logic clr_i,
    output logic present_o
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

    det_state_t det_q, det_d;
    logic [GW-1:0] gap_q, gap_d;
    logic tone_q;
    logic tone_edge;

    assign tone_edge = tone_i ^ tone_q;

    // next state
    always_comb begin
        det_d = det_q;
        if (clr_i) begin
            det_d = DET_IDLE;
        end else begin
            unique case (det_q)
                DET_IDLE:   if (tone_edge) det_d = DET_ARMED;
                DET_ARMED: begin
                    if (tone_edge)               det_d = DET_ACTIVE;
                    else if (gap_q == GAP_LAST)  det_d = DET_IDLE;
                end
                DET_ACTIVE: if (!tone_edge && gap_q == GAP_LAST) det_d = DET_IDLE;
                default:    det_d = DET_IDLE;
            endcase
        end
    end

    always_comb begin
        if (tone_edge || clr_i)    gap_d = '0;
        else if (gap_q < GAP_LAST) gap_d = gap_q + 1'b1;
        else                       gap_d = gap_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q  <= DET_IDLE;
            gap_q  <= '0;
            tone_q <= 1'b0;
        end else begin
            det_q  <= det_d;
            gap_q  <= gap_d;
            tone_q <= tone_i;
        end
    end

    // outputs
    always_comb begin
        unique case (det_q)
            DET_ACTIVE: present_o = 1'b1;
            default:    present_o = 1'b0;
        endcase
    end

    // R4: one edge alone can never reach the active state
    p_two_edges_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q == DET_IDLE) |=> (det_q != DET_ACTIVE));

    // R4: an armed detector with no edge at the gap limit falls back to idle
    p_armed_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q == DET_ARMED && gap_q == GAP_LAST && !tone_edge && !clr_i)
        |=> (det_q == DET_IDLE));

endmodule

// File: rtl/csc_seq.sv
module csc_seq
    import csc_pkg::*;
#(
    parameter int INHIBIT_CYC = 90,
    parameter int SQE_DLY     = 11,
    parameter int SQE_WID     = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic tx_i,
    input  logic loop_i,
    input  logic abort_i,
    output logic carrier_o,
    output logic sqe_o
);
    localparam int CW = $clog2(INHIBIT_CYC + 1);
    localparam logic [CW-1:0] INH_LAST  = CW'(INHIBIT_CYC - 1);
    localparam logic [CW-1:0] SQE_START = CW'(SQE_DLY - 1);
    localparam logic [CW-1:0] SQE_LAST  = CW'(SQE_DLY + SQE_WID - 1);

    seq_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic in_post_q, in_post_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (abort_i)    state_d = ST_ABORT;
                else if (act_i) state_d = tx_i ? ST_TX_CARRIER : ST_RX_CARRIER;
            end
            ST_RX_CARRIER: begin
                if (abort_i)     state_d = ST_ABORT;
                else if (!act_i) state_d = ST_IDLE;
                else if (tx_i)   state_d = ST_TX_CARRIER;
            end
            ST_TX_CARRIER: begin
                if (abort_i)     state_d = ST_ABORT;
                else if (!act_i) state_d = loop_i ? ST_SQE_WAIT : ST_INHIBIT;
            end
            ST_SQE_WAIT:  if (cnt_q == SQE_START) state_d = ST_SQE_PULSE;
            ST_SQE_PULSE: if (cnt_q == SQE_LAST)  state_d = ST_INHIBIT;
            ST_INHIBIT: begin
                if (cnt_q == INH_LAST) begin
                    if (abort_i)    state_d = ST_ABORT;
                    else if (act_i) state_d = tx_i ? ST_TX_CARRIER : ST_RX_CARRIER;
                    else            state_d = ST_IDLE;
                end
            end
            ST_ABORT: if (!tx_i && !abort_i) state_d = ST_INHIBIT;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_post_q = (state_q == ST_SQE_WAIT) || (state_q == ST_SQE_PULSE) ||
                    (state_q == ST_INHIBIT);
        in_post_d = (state_d == ST_SQE_WAIT) || (state_d == ST_SQE_PULSE) ||
                    (state_d == ST_INHIBIT);
        cnt_d = (in_post_q && in_post_d) ? cnt_q + 1'b1 : '0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        carrier_o = 1'b0;
        sqe_o     = 1'b0;
        unique case (state_q)
            ST_RX_CARRIER, ST_TX_CARRIER: carrier_o = 1'b1;
            ST_SQE_PULSE:                 sqe_o     = 1'b1;
            default: ;
        endcase
    end

    // R3: carrier stays off through the window until its last cycle
    p_inhibit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_post_q && cnt_q < INH_LAST) |=> !carrier_o);

    // R2: a reception that ends returns straight to idle
    p_rx_no_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RX_CARRIER && !act_i && !abort_i) |=> (state_q == ST_IDLE));

    // R7: the test pulse never starts before the delay has run out
    p_sqe_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SQE_WAIT) |-> (cnt_q < CW'(SQE_DLY)));

    // R7: the test pulse holds until its full width
    p_sqe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sqe_o && cnt_q < SQE_LAST) |=> sqe_o);

    // R8: an abort never lets carrier through on the next cycle
    p_abort_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !carrier_o);

endmodule

// File: rtl/csc_polarity.sv
module csc_polarity #(
    parameter int W = 2
) (
    input  logic         invert_i,
    input  logic [W-1:0] active_i,
    output logic [W-1:0] pin_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign pin_o[b] = active_i[b] ^ invert_i;
    end
endmodule

// File: rtl/carrier_sense_ctrl.sv
module carrier_sense_ctrl #(
    parameter int INHIBIT_CYC = 90,
    parameter int SQE_DLY     = 11,
    parameter int SQE_WID     = 13,
    parameter int GAP_CYC     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_active,
    input  logic tx_active,
    input  logic coll_tone,
    input  logic wdog_abort,
    input  logic loopback,
    input  logic invert_pol,
    output logic crs_pin,
    output logic coll_pin
);
    logic coll_present;
    logic activity;
    logic carrier;
    logic sqe;
    logic coll_act;
    logic [1:0] pins;

    csc_coll_detect #(.GAP_CYC(GAP_CYC)) i_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .tone_i   (coll_tone),
        .clr_i    (loopback),
        .present_o(coll_present)
    );

    assign activity = loopback ? tx_active : (rx_active | coll_present);

    csc_seq #(
        .INHIBIT_CYC(INHIBIT_CYC),
        .SQE_DLY    (SQE_DLY),
        .SQE_WID    (SQE_WID)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (activity),
        .tx_i     (tx_active),
        .loop_i   (loopback),
        .abort_i  (wdog_abort),
        .carrier_o(carrier),
        .sqe_o    (sqe)
    );

    assign coll_act = sqe | (~loopback & coll_present);

    csc_polarity #(.W(2)) i_pol (
        .invert_i(invert_pol),
        .active_i({coll_act, carrier}),
        .pin_o   (pins)
    );

    assign crs_pin  = pins[0];
    assign coll_pin = pins[1];

    // R6: loopback clears the collision detector
    p_lb_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loopback |=> !coll_present);

    // R6: in loopback with transmit idle, carrier is off next cycle
    p_lb_no_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback && !tx_active) |=> !carrier);

endmodule

// File: tb/test_carrier_sense_ctrl.sv
module test_carrier_sense_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_active = 1'b0, tx_active = 1'b0, coll_tone = 1'b0;
    logic wdog_abort = 1'b0, loopback = 1'b0, invert_pol = 1'b0;
    logic crs_pin, coll_pin;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  crs;
        logic  coll;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    carrier_sense_ctrl i_carrier_sense_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .tx_active(tx_active),
        .coll_tone(coll_tone), .wdog_abort(wdog_abort), .loopback(loopback),
        .invert_pol(invert_pol), .crs_pin(crs_pin), .coll_pin(coll_pin)
    );

    task automatic push(input int off, input logic c, input logic l, input string tag);
        exp_t e;
        e.at = cyc + off; e.crs = c; e.coll = l; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: samples 3 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #3;
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (e.at < cyc || crs_pin !== e.crs || coll_pin !== e.coll) begin
                    n_fail++;
                    $display("FAIL %s cyc=%0d actual crs=%b coll=%b expected crs=%b coll=%b",
                             e.tag, cyc, crs_pin, coll_pin, e.crs, e.coll);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // driver
    initial begin
        step(3);
        rst_n = 1'b1;
        push(1, 0, 0, "R10 reset state");
        step(3);

        // reception: no window afterwards
        rx_active = 1'b1; push(1, 1, 0, "R1 rx carrier");
        step(5);
        rx_active = 1'b0; push(1, 0, 0, "R2 rx end");
        step(1);
        rx_active = 1'b1; push(1, 1, 0, "R2 immediate reassert");
        step(3);
        rx_active = 1'b0; step(4);

        // transmission: 90-cycle window
        rx_active = 1'b1; tx_active = 1'b1; push(1, 1, 0, "R1 tx carrier");
        step(5);
        rx_active = 1'b0; tx_active = 1'b0;
        push(1, 0, 0, "R3 drop");
        push(50, 0, 0, "R3 mid window");
        push(90, 0, 0, "R3 last inhibited");
        push(91, 1, 0, "R3 reassert after window");
        step(1);
        rx_active = 1'b1;
        step(95);
        rx_active = 1'b0; step(4);

        // single edge is not a collision
        coll_tone = 1'b1;
        push(2, 0, 0, "R4 single edge");
        push(6, 0, 0, "R4 single edge timeout");
        step(8);

        // tone: six toggles every other cycle
        push(3, 0, 1, "R5 coll after second edge");
        push(4, 1, 1, "R1 carrier from collision");
        push(14, 1, 1, "R4 still present");
        push(15, 1, 0, "R4 gap drop");
        push(16, 0, 0, "R2 carrier after collision");
        for (int i = 0; i < 6; i++) begin
            coll_tone = ~coll_tone;
            step(2);
        end
        step(8);

        // loopback: line inputs ignored
        loopback = 1'b1; rx_active = 1'b1;
        push(1, 0, 0, "R6 rx ignored");
        push(3, 0, 0, "R6 rx ignored later");
        step(1);
        for (int i = 0; i < 4; i++) begin
            coll_tone = ~coll_tone;
            step(2);
        end
        push(1, 0, 0, "R6 tone ignored");
        step(2);
        tx_active = 1'b1; push(1, 1, 0, "R6 carrier follows tx");
        step(4);
        tx_active = 1'b0;
        push(1, 0, 0, "R7 drop");
        push(11, 0, 0, "R7 before pulse");
        push(12, 0, 1, "R7 pulse start");
        push(24, 0, 1, "R7 pulse end");
        push(25, 0, 0, "R7 after pulse");
        push(91, 0, 0, "R6 rx still ignored");
        step(95);
        loopback = 1'b0; rx_active = 1'b0;
        step(4);

        // watchdog abort
        tx_active = 1'b1; rx_active = 1'b1; push(1, 1, 0, "R8 tx carrier");
        step(4);
        wdog_abort = 1'b1; push(1, 0, 0, "R8 abort drop");
        step(3);
        wdog_abort = 1'b0; push(2, 0, 0, "R8 held while tx");
        step(3);
        tx_active = 1'b0; rx_active = 1'b0;
        push(5, 0, 0, "R8 window after abort");
        push(90, 0, 0, "R8 window last");
        push(91, 1, 0, "R8 reassert after window");
        step(1);
        rx_active = 1'b1;
        step(95);
        rx_active = 1'b0; step(4);

        // inverted polarity
        invert_pol = 1'b1; push(1, 1, 1, "R9 idle inverted");
        step(2);
        rx_active = 1'b1; push(1, 0, 1, "R9 crs active low");
        step(3);
        push(3, 0, 0, "R9 coll active low");
        push(7, 0, 1, "R9 coll released");
        coll_tone = ~coll_tone; step(2);
        coll_tone = ~coll_tone; step(8);
        rx_active = 1'b0;
        step(4);

        while (sb.size() > 0) step(1);
        step(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule